// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces a small processor core. It splits each instruction cycle into four input clocks, called phases Q1 to Q4. It generates the strobes that move one instruction through a two-stage pipeline. While the instruction register holds the instruction that is executing, the program counter already addresses the next one. At the Q1 edge of every cycle the fetched word moves into the instruction register. The counter then steps to the following address. The executing instruction gets a data-memory read strobe in Q2 and a write strobe in Q4.

Decode logic outside the block reports a taken branch and its destination during Q4. The sequencer then loads the destination into the program counter. In the next cycle it puts a bubble word into the instruction register in place of the word that was fetched. That bubble cycle also fetches the destination. A taken branch therefore costs two instruction cycles, and every other instruction costs one. The ALU, the decoder and the memories are outside this block. Program memory is modelled as combinational: it returns the word at `pc_o` on `pmem_data_i`.

Top module: `quad_phase_seq`

## Requirements
- R1: `phase_o` is one-hot at all times, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. While the block runs, the phase advances one step per clock edge in the order Q1, Q2, Q3, Q4, Q1.
- R2: While reset is active the outputs are as follows. `phase_o` = 4'b0001 (Q1). `pc_o` = RESET_VEC (default 9'h1FF). `ir_o` = NOP_WORD (default 12'h000). `ex_valid_o` = 0. Every strobe output (`pc_inc_o`, `ir_load_o`, `dmem_rd_o`, `dmem_wr_o`, `flush_o`) is 0.
- R3: In a Q1 that is not a flush, `pc_inc_o` is 1 and `pc_o` increases by one at the closing edge, wrapping from all-ones to zero. `pc_o` does not change at the Q2 and Q3 edges.
- R4: `ir_load_o` is 1 in every Q1. In a Q1 that is not a flush, the closing edge stores `pmem_data_i` (the word at `pc_o`) into `ir_o` and sets `ex_valid_o`. `ir_o` then holds that word through Q2, Q3 and Q4. Sequential code therefore completes one instruction every four clocks.
- R5: `dmem_rd_o` is 1 exactly in Q2 and `dmem_wr_o` is 1 exactly in Q4, each only while `ex_valid_o` is 1.
- R6: If `branch_taken_i` is 1 in Q4 while `ex_valid_o` is 1, the closing edge loads `branch_target_i` into `pc_o`.
- R7: In the Q1 after an accepted branch, `flush_o` is 1 and `pc_inc_o` is 0. The closing edge loads NOP_WORD into `ir_o`, clears `ex_valid_o` and leaves `pc_o` at the branch target. The branch therefore takes two instruction cycles.
- R8: `branch_taken_i` has no effect in Q1, Q2 or Q3, and no effect in a Q4 where `ex_valid_o` is 0 (a bubble cycle).
- R9: Lowering `rst_n` resets the block at once, with no clock needed. After `rst_n` rises, the block holds its reset state for two clock edges, and the third edge performs the first Q1 action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| branch_taken_i | input | 1 | Executing instruction changes the PC (sampled in Q4) |
| branch_target_i | input | PC_W | New PC value for a taken branch |
| pmem_data_i | input | INSTR_W | Program-memory word at `pc_o` |
| phase_o | output | 4 | One-hot phase, bit 0 = Q1 ... bit 3 = Q4 |
| pc_o | output | PC_W | Program counter, the fetch address |
| pc_inc_o | output | 1 | PC increments at the end of this clock |
| ir_load_o | output | 1 | Instruction register loads at the end of this clock |
| ir_o | output | INSTR_W | Instruction register contents |
| ex_valid_o | output | 1 | Instruction register holds a real instruction |
| dmem_rd_o | output | 1 | Operand read strobe (Q2) |
| dmem_wr_o | output | 1 | Destination write strobe (Q4) |
| flush_o | output | 1 | Fetched word is being discarded in this Q1 |

## Verification
The assertions check on every cycle that the phase is one-hot, that it steps in order, and that the PC moves only at a Q1 increment or a Q4 branch. They also check that the instruction register stays frozen from Q2 to Q4, that a flush leaves a bubble, and that the read and write strobes never coincide. The bench shows what a cycle-local property cannot. Its scenarios cover the cycle count of a branch (its target is fetched after exactly one bubble) and a branch request held high across bubble cycles that must be ignored. They also cover PC wrap-around, and the two-edge delay after reset release together with the immediate effect of reset assertion.

// File: rtl/quad_phase_pkg.sv
package quad_phase_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;

endpackage

// File: rtl/qps_reset_sync.sv
module qps_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
  import quad_phase_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_sync_n,
  output phase_e                phase_q,
  output logic [NUM_PHASES-1:0] phase_oh
);

  phase_e phase_d;
  logic   adv_en;

  assign adv_en = rst_sync_n;

  always_comb begin
    unique case (phase_q)
      PH_Q1:   phase_d = PH_Q2;
      PH_Q2:   phase_d = PH_Q3;
      PH_Q3:   phase_d = PH_Q4;
      default: phase_d = PH_Q1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_Q1;
    end else if (adv_en) begin
      phase_q <= phase_d;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign phase_oh[g] = (phase_q == phase_e'(g));

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      phase_oh[g] |=> phase_oh[(g + 1) % NUM_PHASES]);  // R1
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot(phase_oh));  // R1

endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
  parameter int unsigned         PC_W      = 9,
  parameter logic [PC_W-1:0]     RESET_VEC = '1
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            q1_en,
  input  logic            q2_en,
  input  logic            q3_en,
  input  logic            q4_en,
  input  logic            ex_valid_i,
  input  logic            branch_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_q,
  output logic            pc_inc,
  output logic            kill_q
);

  logic            br_accept;
  logic            pc_en;
  logic [PC_W-1:0] pc_d;
  logic            kill_en;
  logic            kill_d;

  // A branch counts only at the end of a real instruction's Q4.
  assign br_accept = q4_en & branch_i & ex_valid_i;

  // The bubble cycle after a branch fetches the target, so the PC waits.
  assign pc_inc = q1_en & ~kill_q;

  always_comb begin
    pc_en = pc_inc | br_accept;
    if (br_accept) begin
      pc_d = target_i;
    end else begin
      pc_d = pc_q + PC_W'(1);
    end
  end

  always_comb begin
    kill_en = br_accept | q1_en;
    kill_d  = br_accept;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= RESET_VEC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kill_q <= 1'b0;
    end else if (kill_en) begin
      kill_q <= kill_d;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_inc |=> pc_q == $past(pc_q) + PC_W'(1));  // R3

  AST_PC_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q2_en | q3_en) |=> $stable(pc_q));  // R3

  AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q4_en && branch_i && ex_valid_i) |=> pc_q == $past(target_i));  // R6

  AST_BUBBLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q1_en && kill_q) |=> $stable(pc_q));  // R7

  AST_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q4_en && !ex_valid_i) |=> $stable(pc_q));  // R8

endmodule

// File: rtl/qps_ir_stage.sv
module qps_ir_stage #(
  parameter int unsigned           INSTR_W  = 12,
  parameter logic [INSTR_W-1:0]    NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic               q1_en,
  input  logic               q2_en,
  input  logic               q3_en,
  input  logic               q4_en,
  input  logic               kill_i,
  input  logic [INSTR_W-1:0] fetch_word_i,
  output logic [INSTR_W-1:0] ir_q,
  output logic               valid_q,
  output logic               ir_load,
  output logic               rd_stb,
  output logic               wr_stb,
  output logic               flush
);

  logic [INSTR_W-1:0] ir_d;
  logic               valid_d;

  assign ir_load = q1_en;
  assign flush   = q1_en & kill_i;

  always_comb begin
    if (kill_i) begin
      ir_d    = NOP_WORD;
      valid_d = 1'b0;
    end else begin
      ir_d    = fetch_word_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ir_q    <= NOP_WORD;
      valid_q <= 1'b0;
    end else if (ir_load) begin
      ir_q    <= ir_d;
      valid_q <= valid_d;
    end
  end

  assign rd_stb = q2_en & valid_q;
  assign wr_stb = q4_en & valid_q;

  AST_IR_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q2_en | q3_en | q4_en) |=> ($stable(ir_q) && $stable(valid_q)));  // R4

  AST_IR_FETCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q1_en && !kill_i) |=> (ir_q == $past(fetch_word_i) && valid_q));  // R4

  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (ir_q == NOP_WORD && !valid_q));  // R7

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_stb && wr_stb));  // R5

endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import quad_phase_pkg::*;
#(
  parameter int unsigned        PC_W      = 9,
  parameter int unsigned        INSTR_W   = 12,
  parameter logic [PC_W-1:0]    RESET_VEC = '1,
  parameter logic [INSTR_W-1:0] NOP_WORD  = '0,
  parameter int unsigned        SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               branch_taken_i,
  input  logic [PC_W-1:0]    branch_target_i,
  input  logic [INSTR_W-1:0] pmem_data_i,
  output logic [3:0]         phase_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               pc_inc_o,
  output logic               ir_load_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               ex_valid_o,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o,
  output logic               flush_o
);

  logic                  rst_sync_n;
  phase_e                phase_q;
  logic [NUM_PHASES-1:0] phase_oh;
  logic [NUM_PHASES-1:0] ph_en;
  logic                  kill_q;
  logic                  valid_q;

  qps_reset_sync #(
    .STAGES (SYNC_STG)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qps_phase_gen u_phase (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .phase_q    (phase_q),
    .phase_oh   (phase_oh)
  );

  // Phase enables that drive actions stay low while reset is held.
  assign ph_en = phase_oh & {NUM_PHASES{rst_sync_n}};

  qps_pc_unit #(
    .PC_W      (PC_W),
    .RESET_VEC (RESET_VEC)
  ) u_pc (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .q1_en      (ph_en[PH_Q1]),
    .q2_en      (ph_en[PH_Q2]),
    .q3_en      (ph_en[PH_Q3]),
    .q4_en      (ph_en[PH_Q4]),
    .ex_valid_i (valid_q),
    .branch_i   (branch_taken_i),
    .target_i   (branch_target_i),
    .pc_q       (pc_o),
    .pc_inc     (pc_inc_o),
    .kill_q     (kill_q)
  );

  qps_ir_stage #(
    .INSTR_W  (INSTR_W),
    .NOP_WORD (NOP_WORD)
  ) u_ir (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .q1_en        (ph_en[PH_Q1]),
    .q2_en        (ph_en[PH_Q2]),
    .q3_en        (ph_en[PH_Q3]),
    .q4_en        (ph_en[PH_Q4]),
    .kill_i       (kill_q),
    .fetch_word_i (pmem_data_i),
    .ir_q         (ir_o),
    .valid_q      (valid_q),
    .ir_load      (ir_load_o),
    .rd_stb       (dmem_rd_o),
    .wr_stb       (dmem_wr_o),
    .flush        (flush_o)
  );

  assign phase_o    = phase_oh;
  assign ex_valid_o = valid_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !(pc_inc_o || ir_load_o || dmem_rd_o || dmem_wr_o || flush_o));  // R2

  AST_PHASE_STEP_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ph_en[PH_Q4] |=> phase_o[PH_Q1]);  // R1

endmodule

// File: tb/quad_phase_seq_bench.sv
module quad_phase_seq_bench;

  localparam int unsigned        PC_W      = 9;
  localparam int unsigned        INSTR_W   = 12;
  localparam logic [PC_W-1:0]    RESET_VEC = 9'h1FF;
  localparam logic [INSTR_W-1:0] NOP_WORD  = 12'h000;
  localparam int unsigned        WD_CYCLES = 150000;

  logic               clk;
  logic               rst_n;
  logic               branch_taken_i;
  logic [PC_W-1:0]    branch_target_i;
  logic [INSTR_W-1:0] pmem_data_i;
  logic [3:0]         phase_o;
  logic [PC_W-1:0]    pc_o;
  logic               pc_inc_o;
  logic               ir_load_o;
  logic [INSTR_W-1:0] ir_o;
  logic               ex_valid_o;
  logic               dmem_rd_o;
  logic               dmem_wr_o;
  logic               flush_o;

  int checks = 0;
  int errors = 0;
  string scen = "R2";

  quad_phase_seq #(
    .PC_W      (PC_W),
    .INSTR_W   (INSTR_W),
    .RESET_VEC (RESET_VEC),
    .NOP_WORD  (NOP_WORD)
  ) u_quad_phase_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .branch_taken_i  (branch_taken_i),
    .branch_target_i (branch_target_i),
    .pmem_data_i     (pmem_data_i),
    .phase_o         (phase_o),
    .pc_o            (pc_o),
    .pc_inc_o        (pc_inc_o),
    .ir_load_o       (ir_load_o),
    .ir_o            (ir_o),
    .ex_valid_o      (ex_valid_o),
    .dmem_rd_o       (dmem_rd_o),
    .dmem_wr_o       (dmem_wr_o),
    .flush_o         (flush_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [INSTR_W-1:0] word_at(input logic [PC_W-1:0] a);
    return INSTR_W'({3'b000, a} * 12'd181) ^ 12'h5A3;
  endfunction

  // Combinational program memory.
  always_comb pmem_data_i = word_at(pc_o);

  // Requirement model.
  logic [1:0]         m_ph;
  logic [PC_W-1:0]    m_pc;
  logic [INSTR_W-1:0] m_ir;
  logic               m_val;
  logic               m_kill;
  int                 rel_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt <= 0;
      m_ph <= 2'd0; m_pc <= RESET_VEC; m_ir <= NOP_WORD; m_val <= 1'b0; m_kill <= 1'b0;
    end else begin
      if (rel_cnt < 3) rel_cnt <= rel_cnt + 1;
      if (rel_cnt >= 2) begin
        m_ph <= m_ph + 2'd1;
        case (m_ph)
          2'd0: begin
            if (m_kill) begin
              m_ir <= NOP_WORD; m_val <= 1'b0;
            end else begin
              m_ir <= word_at(m_pc); m_val <= 1'b1; m_pc <= m_pc + 9'd1;
            end
            m_kill <= 1'b0;
          end
          2'd3: begin
            if (branch_taken_i && m_val) begin
              m_pc <= branch_target_i; m_kill <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %0h expected %0h", tag, scen, act, exp);
    end
  endtask

  task automatic compare_all();
    logic run;
    run = rst_n && (rel_cnt >= 2);
    chk("R1 phase", 32'(phase_o), 32'(4'b0001 << m_ph));
    chk("R3 R6 pc", 32'(pc_o), 32'(m_pc));
    chk("R4 R7 ir", 32'(ir_o), 32'(m_ir));
    chk("R4 R7 valid", 32'(ex_valid_o), 32'(m_val));
    chk("R3 R7 pc_inc", 32'(pc_inc_o), 32'(run && m_ph == 2'd0 && !m_kill));
    chk("R4 ir_load", 32'(ir_load_o), 32'(run && m_ph == 2'd0));
    chk("R5 rd", 32'(dmem_rd_o), 32'(run && m_ph == 2'd1 && m_val));
    chk("R5 wr", 32'(dmem_wr_o), 32'(run && m_ph == 2'd3 && m_val));
    chk("R7 flush", 32'(flush_o), 32'(run && m_ph == 2'd0 && m_kill));
  endtask

  task automatic run_cycles(input int n, input int br_mode, input logic [PC_W-1:0] tgt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      case (br_mode)
        0: begin branch_taken_i = 1'b0; branch_target_i = PC_W'($urandom); end
        1: begin branch_taken_i = ($urandom % 4) == 0; branch_target_i = PC_W'($urandom); end
        default: begin branch_taken_i = 1'b1; branch_target_i = tgt; end
      endcase
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    branch_taken_i = 1'b1;
    branch_target_i = 9'h055;
    repeat (3) @(negedge clk);
    // R2: reset state while held, branch input high.
    chk("R2 phase", 32'(phase_o), 32'h1);
    chk("R2 pc", 32'(pc_o), 32'(RESET_VEC));
    chk("R2 ir", 32'(ir_o), 32'(NOP_WORD));
    chk("R2 valid", 32'(ex_valid_o), 32'h0);
    chk("R2 strobes", 32'({pc_inc_o, ir_load_o, dmem_rd_o, dmem_wr_o, flush_o}), 32'h0);
    branch_taken_i = 1'b0;
    rst_n = 1'b1;
    // R9: two held edges, then run; sequential code wraps 1FF to 000 (R3).
    scen = "R9 R3 R4";
    run_cycles(400, 0, '0);
    scen = "R6 R7";
    run_cycles(2000, 1, '0);
    // R8: branch held high: every bubble Q4 and Q1..Q3 must be ignored.
    scen = "R8";
    run_cycles(300, 2, 9'h1FE);
    scen = "R6 wrap";
    run_cycles(200, 2, 9'h1FF);
    // R9: asynchronous assertion takes effect before any clock edge.
    @(negedge clk);
    compare_all();
    #3 rst_n = 1'b0;
    #2;
    chk("R9 async pc", 32'(pc_o), 32'(RESET_VEC));
    chk("R9 async valid", 32'(ex_valid_o), 32'h0);
    chk("R9 async phase", 32'(phase_o), 32'h1);
    chk("R9 async strobes", 32'({pc_inc_o, ir_load_o, dmem_rd_o, dmem_wr_o, flush_o}), 32'h0);
    branch_taken_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    scen = "R9 release";
    run_cycles(1500, 1, '0);
    summary();
    $finish;
  end

endmodule